// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a single operation request into the byte-wide write cycles that a parallel NOR flash needs before it will act. Every command starts with a two-write unlock handshake to two fixed offsets. Each command then adds its own command byte or bytes. Program-entry, ID-entry and ID-exit commands are three writes long. The three erase commands are six writes long. The sequencer adds idle settle intervals between cycles where the flash needs them. These intervals are counted in clock cycles derived from a clock-frequency parameter, and a single-cycle completion pulse follows them.

For ID entry, the block goes on to read the manufacturer and device identifiers. It follows continuation codes to a second byte. It also checks the final manufacturer byte for odd parity. The settle interval after an ID command is set per request. The request can give an explicit time in microseconds, select a default, turn all ID waits off, or refuse the command without touching the bus.

All magic offsets and the target address are added to a base address, which is captured with the request. A request is taken only while the sequencer is idle. Polling for completion and checking the result are left to the logic around the block.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every accepted, non-aborted command begins with the write 0xAA at base+0x5555, followed by 0x55 at base+0x2AAA.
- R2: The op code is 3 bits wide. Op 0 (program entry) writes 0xA0 as its third cycle, op 1 (ID entry) writes 0x90, and op 2 (ID exit) writes 0xF0, each at base+0x5555. Program entry has no idle cycles: its writes fall in consecutive cycles, and done comes in the cycle after the third write.
- R3: Erase commands write six cycles: the unlock pair, 0x80 at base+0x5555, the unlock pair again, and a final byte. The final byte is 0x10 at base+0x5555 for op 5 (chip erase), 0x30 at base+target for op 3 (sector erase), and 0x50 at base+target for op 4 (block erase).
- R4: During an erase, exactly 10*CLK_MHZ idle cycles follow each of the six writes. Done is asserted in the cycle after the last idle cycle.
- R5: For ID commands, settle_us selects the waits. If settle_us is not 0, 10*CLK_MHZ idle cycles follow each of the first two writes. After the third write, the idle time is settle_us*CLK_MHZ cycles when settle_us > 0. When settle_us = -1 it is 10000*CLK_MHZ cycles for ID entry and 40*CLK_MHZ cycles for ID exit. When settle_us = 0 there are no idle cycles at all.
- R6: An ID command with settle_us < -1 completes with done and aborted in the cycle after acceptance, and issues no bus cycle. Other ops ignore settle_us.
- R7: Op codes 6 and 7 complete with done and aborted in the cycle after acceptance, and issue no bus cycle.
- R8: After its settle time, ID entry reads offsets 0 and 1 in consecutive cycles. It then reads 0x100 if the byte at offset 0 was 0x7F, and then 0x101 if the byte at offset 1 was 0x7F. bus_rdata is sampled in the cycle in which bus_rd is high. id_mfr and id_dev become {0x7F, continuation byte} when a continuation was read, and {0x00, byte} otherwise.
- R9: id_parity_err is high exactly when id_valid is high and the low byte of id_mfr holds an even number of ones.
- R10: start is accepted only when busy is low; a start while busy has no effect on the bus sequence. The op, target, base and settle_us inputs are captured at acceptance. Acceptance clears id_valid, and a completed, non-aborted ID entry sets it.
- R11: While reset is asserted and after it is released, busy, done, aborted, bus_we, bus_rd and id_valid are low.
- R12: done is a single-cycle pulse, aborted is high only together with done, and busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, taken when idle |
| op | input | 3 | Operation code |
| target | input | AW | Sector or block offset for erase |
| base | input | AW | Base address added to every offset |
| settle_us | input | 16 | Signed ID settle selection in microseconds |
| busy | output | 1 | A command is in progress |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | 8 | Flash write data |
| bus_we | output | 1 | Write cycle strobe |
| bus_rd | output | 1 | Read cycle strobe |
| bus_rdata | input | 8 | Flash read data, sampled while bus_rd is high |
| done | output | 1 | Completion pulse |
| aborted | output | 1 | Command was refused, with done |
| id_valid | output | 1 | ID results are from the last completed ID entry |
| id_mfr | output | 16 | Manufacturer ID, with continuation byte |
| id_dev | output | 16 | Device ID, with continuation byte |
| id_parity_err | output | 1 | Final manufacturer byte has even parity |

## Verification
The bench records each bus cycle and the done pulse with its cycle number. It compares the addresses, data and exact gaps with a sequence that bench functions build from the op, the target, the base and settle_us. Directed cases cover each op code and each settle selection: positive, zero, default and refusing. A positive settle value separates the per-request settle path from the fixed defaults. Zero shows that the inter-unlock waits are gated, and a value of -2 or below shows that the bus stays untouched.

Identifier patterns place 0x7F at the first, second, both or neither read position, which tells apart the continuation ordering and the lane that receives each byte. Manufacturer bytes of odd and even weight exercise the parity flag. A start pulsed in the middle of an erase shows that requests are locked out while busy. Random requests mix all of these, including target and base values that differ between runs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [2:0] OP_PROG       = 3'd0;
  localparam logic [2:0] OP_ID_ENTER   = 3'd1;
  localparam logic [2:0] OP_ID_EXIT    = 3'd2;
  localparam logic [2:0] OP_SECT_ERASE = 3'd3;
  localparam logic [2:0] OP_BLK_ERASE  = 3'd4;
  localparam logic [2:0] OP_CHIP_ERASE = 3'd5;

  localparam logic [15:0] KEY_OFF_A = 16'h5555;
  localparam logic [15:0] KEY_OFF_B = 16'h2AAA;
  localparam logic [7:0]  CONT_CODE = 8'h7F;

  typedef enum logic [1:0] {AS_KEY_A, AS_KEY_B, AS_TGT} addr_sel_e;
  typedef enum logic [1:0] {WT_NONE, WT_SHORT, WT_SETTLE} wait_kind_e;

  typedef struct packed {
    logic [7:0] data;
    addr_sel_e  asel;
    wait_kind_e wkind;
    logic       last;
  } step_t;

  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_WAIT, ST_RD, ST_DONE} seq_state_e;

endpackage

// File: rtl/fcs_step_table.sv
module fcs_step_table
  import fcs_pkg::*;
(
  input  logic [2:0] op,
  input  logic [2:0] idx,
  output step_t      step
);

  logic is_erase;
  logic is_id;

  assign is_erase = (op == OP_SECT_ERASE) || (op == OP_BLK_ERASE) || (op == OP_CHIP_ERASE);
  assign is_id    = (op == OP_ID_ENTER) || (op == OP_ID_EXIT);

  always_comb begin
    step.data  = 8'h00;
    step.asel  = AS_KEY_A;
    step.wkind = WT_NONE;
    step.last  = 1'b0;
    case (idx)
      3'd0, 3'd3: begin
        step.data  = 8'hAA;
        step.asel  = AS_KEY_A;
        step.wkind = (is_erase || is_id) ? WT_SHORT : WT_NONE;
      end
      3'd1, 3'd4: begin
        step.data  = 8'h55;
        step.asel  = AS_KEY_B;
        step.wkind = (is_erase || is_id) ? WT_SHORT : WT_NONE;
      end
      3'd2: begin
        step.asel = AS_KEY_A;
        if (is_erase) begin
          step.data  = 8'h80;
          step.wkind = WT_SHORT;
        end else begin
          step.last = 1'b1;
          case (op)
            OP_ID_ENTER: step.data = 8'h90;
            OP_ID_EXIT:  step.data = 8'hF0;
            default:     step.data = 8'hA0;
          endcase
          step.wkind = is_id ? WT_SETTLE : WT_NONE;
        end
      end
      3'd5: begin
        step.last  = 1'b1;
        step.wkind = WT_SHORT;
        case (op)
          OP_SECT_ERASE: begin step.data = 8'h30; step.asel = AS_TGT; end
          OP_BLK_ERASE:  begin step.data = 8'h50; step.asel = AS_TGT; end
          default:       begin step.data = 8'h10; step.asel = AS_KEY_A; end
        endcase
      end
      default: begin
        step.last = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fcs_wait_timer.sv
module fcs_wait_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == {{(TW-1){1'b0}}, 1'b1});

  // an idle counter stays idle until reloaded (R4)
  assert_tmr_idle_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // a loaded count falls by one per cycle (R4)
  assert_tmr_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q > 1 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fcs_id_capture.sv
module fcs_id_capture
  import fcs_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        clear,
  input  logic        cap_en,
  input  logic        cap_lane,
  input  logic        cap_cont,
  input  logic [7:0]  rdata,
  output logic [15:0] id_word [LANES]
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [15:0] word_q, word_d;
    logic        hit;

    assign hit = cap_en && (cap_lane == g[0]);

    always_comb begin
      word_d = word_q;
      if (clear)         word_d = '0;
      else if (hit)      word_d = cap_cont ? {word_q[7:0], rdata} : {8'h00, rdata};
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)              word_q <= '0;
      else if (clear || hit)    word_q <= word_d;
    end

    assign id_word[g] = word_q;

    // a continuation read only follows a stored continuation code (R8)
    assert_cont_after_code_R8: assert property (@(posedge clk) disable iff (!rst_ni)
      (hit && cap_cont) |-> (word_q[7:0] == CONT_CODE));
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW      = 20,
  parameter int CLK_MHZ = 50,
  parameter int TW      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           op,
  input  logic [AW-1:0]        target,
  input  logic [AW-1:0]        base,
  input  logic signed [15:0]   settle_us,
  output logic                 busy,
  output logic [AW-1:0]        bus_addr,
  output logic [7:0]           bus_wdata,
  output logic                 bus_we,
  output logic                 bus_rd,
  input  logic [7:0]           bus_rdata,
  output logic                 done,
  output logic                 aborted,
  output logic                 id_valid,
  output logic [15:0]          id_mfr,
  output logic [15:0]          id_dev,
  output logic                 id_parity_err
);

  localparam logic [TW-1:0] SHORT_CYC = TW'(10 * CLK_MHZ);
  localparam logic [TW-1:0] ENTRY_CYC = TW'(10000 * CLK_MHZ);
  localparam logic [TW-1:0] EXIT_CYC  = TW'(40 * CLK_MHZ);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  seq_state_e         state_q, state_d;
  logic [2:0]         op_q;
  logic [AW-1:0]      tgt_q, base_q;
  logic signed [15:0] settle_q;
  logic [2:0]         wr_idx_q, wr_idx_d;
  logic [1:0]         rd_idx_q, rd_idx_d;
  logic               abort_q, valid_q, valid_d;

  logic               accept, start_ok, in_is_id, is_id;
  step_t              cur_step;
  logic [TW-1:0]      wait_len;
  logic               tmr_load, tmr_expire;
  seq_state_e         after_wr;
  logic [AW-1:0]      offs;
  logic [15:0]        id_word [2];

  assign accept   = (state_q == ST_IDLE) && start;
  assign in_is_id = (op == OP_ID_ENTER) || (op == OP_ID_EXIT);
  assign start_ok = (op <= OP_CHIP_ERASE) && !(in_is_id && (settle_us < -16'sd1));
  assign is_id    = (op_q == OP_ID_ENTER) || (op_q == OP_ID_EXIT);

  fcs_step_table u_steps (
    .op   (op_q),
    .idx  (wr_idx_q),
    .step (cur_step)
  );

  always_comb begin
    wait_len = '0;
    case (cur_step.wkind)
      WT_SHORT:  wait_len = (is_id && settle_q == 16'sd0) ? '0 : SHORT_CYC;
      WT_SETTLE: begin
        if (settle_q == 16'sd0)       wait_len = '0;
        else if (settle_q == -16'sd1) wait_len = (op_q == OP_ID_ENTER) ? ENTRY_CYC : EXIT_CYC;
        else                          wait_len = TW'(settle_q[14:0]) * TW'(CLK_MHZ);
      end
      default:   wait_len = '0;
    endcase
  end

  fcs_wait_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (tmr_load),
    .load_val (wait_len),
    .expire   (tmr_expire)
  );

  always_comb begin
    if (!cur_step.last)            after_wr = ST_WR;
    else if (op_q == OP_ID_ENTER)  after_wr = ST_RD;
    else                           after_wr = ST_DONE;
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    tmr_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        wr_idx_d = '0;
        rd_idx_d = '0;
        if (start) state_d = start_ok ? ST_WR : ST_DONE;
      end
      ST_WR: begin
        if (wait_len != '0) begin
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end else begin
          state_d = after_wr;
          if (!cur_step.last) wr_idx_d = wr_idx_q + 3'd1;
        end
      end
      ST_WAIT: begin
        if (tmr_expire) begin
          state_d = after_wr;
          if (!cur_step.last) wr_idx_d = wr_idx_q + 3'd1;
        end
      end
      ST_RD: begin
        case (rd_idx_q)
          2'd0: rd_idx_d = 2'd1;
          2'd1: begin
            if (id_word[0][7:0] == CONT_CODE) rd_idx_d = 2'd2;
            else if (bus_rdata == CONT_CODE)  rd_idx_d = 2'd3;
            else                              state_d  = ST_DONE;
          end
          2'd2: begin
            if (id_word[1][7:0] == CONT_CODE) rd_idx_d = 2'd3;
            else                              state_d  = ST_DONE;
          end
          default: state_d = ST_DONE;
        endcase
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    valid_d = valid_q;
    if (accept)                                       valid_d = 1'b0;
    else if (state_q == ST_RD && state_d == ST_DONE)  valid_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      valid_q  <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      tgt_q    <= '0;
      base_q   <= '0;
      settle_q <= '0;
      abort_q  <= 1'b0;
    end else if (accept) begin
      op_q     <= op;
      tgt_q    <= target;
      base_q   <= base;
      settle_q <= settle_us;
      abort_q  <= !start_ok;
    end
  end

  fcs_id_capture #(.LANES(2)) u_id (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .clear    (accept),
    .cap_en   (state_q == ST_RD),
    .cap_lane (rd_idx_q[0]),
    .cap_cont (rd_idx_q[1]),
    .rdata    (bus_rdata),
    .id_word  (id_word)
  );

  always_comb begin
    if (state_q == ST_RD) begin
      offs = AW'({rd_idx_q[1], 7'b0000000, rd_idx_q[0]});
    end else begin
      case (cur_step.asel)
        AS_KEY_B: offs = AW'(KEY_OFF_B);
        AS_TGT:   offs = tgt_q;
        default:  offs = AW'(KEY_OFF_A);
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign bus_we        = (state_q == ST_WR);
  assign bus_rd        = (state_q == ST_RD);
  assign bus_addr      = base_q + offs;
  assign bus_wdata     = bus_we ? cur_step.data : 8'h00;
  assign done          = (state_q == ST_DONE);
  assign aborted       = done && abort_q;
  assign id_valid      = valid_q;
  assign id_mfr        = id_word[0];
  assign id_dev        = id_word[1];
  assign id_parity_err = valid_q && !(^id_word[0][7:0]);

  // the first write after idle is the first unlock byte (R1)
  assert_first_unlock_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && !$past(busy)) |-> (bus_wdata == 8'hAA));

  // reads and writes never share a cycle (R8)
  assert_bus_excl_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_we && bus_rd));

  // a refused command goes straight from idle to done (R6)
  assert_abort_nobus_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    aborted |-> !$past(busy));

  // done lasts one cycle and returns to idle (R12)
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> (!done && !busy));

  // busy only rises on a start request (R10)
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int AW        = 20;
  localparam int CLK_MHZ   = 2;
  localparam int SHORT     = 10 * CLK_MHZ;
  localparam int ENTRY_DEF = 10000 * CLK_MHZ;
  localparam int EXIT_DEF  = 40 * CLK_MHZ;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [2:0]         op = 3'd0;
  logic [AW-1:0]      target = '0;
  logic [AW-1:0]      base = '0;
  logic signed [15:0] settle_us = 16'sd0;
  logic               busy, bus_we, bus_rd, done, aborted, id_valid, id_parity_err;
  logic [AW-1:0]      bus_addr;
  logic [7:0]         bus_wdata, bus_rdata;
  logic [15:0]        id_mfr, id_dev;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .CLK_MHZ(CLK_MHZ), .TW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .target(target), .base(base),
    .settle_us(settle_us), .busy(busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .done(done),
    .aborted(aborted), .id_valid(id_valid), .id_mfr(id_mfr), .id_dev(id_dev),
    .id_parity_err(id_parity_err)
  );

  // flash ID model
  logic [7:0]    m0 = 8'h00, d0 = 8'h00, m1 = 8'h00, d1 = 8'h00;
  logic [AW-1:0] cur_base = '0;
  logic [AW-1:0] mdl_off;
  assign mdl_off = bus_addr - cur_base;
  always_comb begin
    case (mdl_off)
      AW'(20'h00000): bus_rdata = m0;
      AW'(20'h00001): bus_rdata = d0;
      AW'(20'h00100): bus_rdata = m1;
      AW'(20'h00101): bus_rdata = d1;
      default:        bus_rdata = 8'hFF;
    endcase
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor
  int            cyc = 0;
  int            log_n = 0;
  int            log_kind [32];
  logic [AW-1:0] log_addr [32];
  logic [7:0]    log_data [32];
  int            log_cyc  [32];
  bit            done_seen = 0;
  bit            done_ab = 0;
  int            done_cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (bus_we || bus_rd) begin
      if (log_n < 32) begin
        log_kind[log_n] = bus_rd ? 1 : 0;
        log_addr[log_n] = bus_addr;
        log_data[log_n] = bus_rd ? bus_rdata : bus_wdata;
        log_cyc[log_n]  = cyc;
      end
      log_n++;
    end
    if (done && !done_seen) begin
      done_seen = 1;
      done_cyc  = cyc;
      done_ab   = aborted;
    end
  end

  // expected sequence
  int            e_n, e_pend, e_done_gap;
  int            e_kind [32];
  logic [AW-1:0] e_addr [32];
  logic [7:0]    e_data [32];
  int            e_gap  [32];
  bit            e_abort;
  logic [15:0]   e_mfr, e_dev;
  logic [AW-1:0] e_base;

  task automatic ep(input int k, input int off, input logic [7:0] d);
    e_kind[e_n] = k;
    e_addr[e_n] = e_base + AW'(off);
    e_data[e_n] = d;
    e_gap[e_n]  = e_pend;
    e_n++;
    e_pend = 1;
  endtask

  task automatic ew(input int n);
    e_pend += n;
  endtask

  task automatic exp_build(input logic [2:0] o, input logic [AW-1:0] t,
                           input logic signed [15:0] s);
    bit is_id;
    int sw, st;
    e_n = 0; e_pend = 1; e_abort = 0; e_mfr = '0; e_dev = '0;
    is_id = (o == 3'd1) || (o == 3'd2);
    if (o > 3'd5 || (is_id && s < -16'sd1)) begin
      e_abort = 1; e_done_gap = 1;
      return;
    end
    sw = (s == 0) ? 0 : SHORT;
    if (s == 0)       st = 0;
    else if (s == -1) st = (o == 3'd1) ? ENTRY_DEF : EXIT_DEF;
    else              st = int'(s) * CLK_MHZ;
    if (o == 3'd0) begin
      ep(0, 'h5555, 8'hAA); ep(0, 'h2AAA, 8'h55); ep(0, 'h5555, 8'hA0);
    end else if (is_id) begin
      ep(0, 'h5555, 8'hAA); ew(sw);
      ep(0, 'h2AAA, 8'h55); ew(sw);
      ep(0, 'h5555, (o == 3'd1) ? 8'h90 : 8'hF0); ew(st);
      if (o == 3'd1) begin
        ep(1, 'h000, m0); ep(1, 'h001, d0);
        if (m0 == 8'h7F) ep(1, 'h100, m1);
        if (d0 == 8'h7F) ep(1, 'h101, d1);
        e_mfr = (m0 == 8'h7F) ? {8'h7F, m1} : {8'h00, m0};
        e_dev = (d0 == 8'h7F) ? {8'h7F, d1} : {8'h00, d0};
      end
    end else begin
      ep(0, 'h5555, 8'hAA); ew(SHORT); ep(0, 'h2AAA, 8'h55); ew(SHORT);
      ep(0, 'h5555, 8'h80); ew(SHORT); ep(0, 'h5555, 8'hAA); ew(SHORT);
      ep(0, 'h2AAA, 8'h55); ew(SHORT);
      if (o == 3'd3)      ep(0, int'(t), 8'h30);
      else if (o == 3'd4) ep(0, int'(t), 8'h50);
      else                ep(0, 'h5555, 8'h10);
      ew(SHORT);
    end
    e_done_gap = e_pend;
  endtask

  task automatic run_cmd(input logic [2:0] o, input logic [AW-1:0] t, input logic [AW-1:0] b,
                         input logic signed [15:0] s, input bit inject, input string req);
    int  base_c, lim, prev, bad;
    bit  was_idle;
    e_base = b;
    exp_build(o, t, s);
    @(negedge clk); #1;
    was_idle  = !busy;
    log_n     = 0;
    done_seen = 0;
    cur_base  = b;
    op = o; target = t; base = b; settle_us = s; start = 1'b1;
    base_c = cyc;
    @(negedge clk); #1;
    start = 1'b0; op = 3'($urandom); target = AW'($urandom);
    if (inject) begin
      repeat (3) @(negedge clk);
      #1 start = 1'b1; op = 3'd5;
      @(negedge clk); #1 start = 1'b0;
    end
    lim = 0;
    while (!done_seen && lim < 30000) begin
      @(negedge clk); lim++;
    end
    #1;
    chk(was_idle && done_seen, req, "done reached", done_seen, 1);
    chk(log_n == e_n, req, "bus cycle count", log_n, e_n);
    bad = -1;
    prev = base_c;
    for (int i = 0; i < e_n && i < log_n && i < 32; i++) begin
      if (bad < 0 && (log_kind[i] != e_kind[i] || log_addr[i] != e_addr[i] ||
                      log_data[i] != e_data[i] || (log_cyc[i] - prev) != e_gap[i]))
        bad = i;
      prev = log_cyc[i];
    end
    if (bad >= 0)
      chk(0, req, $sformatf("cycle %0d addr/data/gap", bad),
          {log_addr[bad], log_data[bad], 16'(log_cyc[bad] - (bad == 0 ? base_c : log_cyc[bad-1]))},
          {e_addr[bad], e_data[bad], 16'(e_gap[bad])});
    else
      chk(1, req, "sequence", 0, 0);
    chk((done_cyc - prev) == e_done_gap, req, "done timing", done_cyc - prev, e_done_gap);
    chk(done_ab == e_abort, e_abort ? "R6" : req, "aborted flag", done_ab, e_abort);
    chk(id_valid == (o == 3'd1 && !e_abort), "R10", "id_valid", id_valid, (o == 3'd1 && !e_abort));
    if (o == 3'd1 && !e_abort) begin
      chk(id_mfr == e_mfr, "R8", "id_mfr", id_mfr, e_mfr);
      chk(id_dev == e_dev, "R8", "id_dev", id_dev, e_dev);
      chk(id_parity_err == !(^e_mfr[7:0]), "R9", "parity flag", id_parity_err, !(^e_mfr[7:0]));
    end
    @(negedge clk); #1;
    chk(!done && !busy && !aborted, "R12", "done pulse ended", {done, busy, aborted}, 0);
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R8";
      3'd2: return "R5";
      3'd3, 3'd4, 3'd5: return "R3";
      default: return "R7";
    endcase
  endfunction

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [2:0]         ro;
    logic signed [15:0] rs;
    void'($urandom(32'd9173));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !aborted && !bus_we && !bus_rd && !id_valid, "R11",
        "outputs in reset", {busy, done, aborted, bus_we, bus_rd, id_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !done && !bus_we && !bus_rd && !id_valid, "R11",
        "outputs after release", {busy, done, bus_we, bus_rd, id_valid}, 0);

    // R1 / R2: program entry, unlock pair at shifted base
    run_cmd(3'd0, '0, AW'(20'h10000), 16'sd7, 1'b0, "R1");
    run_cmd(3'd0, '0, '0, 16'sd0, 1'b0, "R2");
    // R3 / R4: each erase flavour
    run_cmd(3'd3, AW'(20'h0A000), AW'(20'h40000), 16'sd0, 1'b0, "R3");
    run_cmd(3'd4, AW'(20'h30000), '0, 16'sd0, 1'b0, "R3");
    run_cmd(3'd5, AW'(20'h12345), AW'(20'h00010), 16'sd0, 1'b0, "R4");
    // R10: start pulsed mid-erase is ignored
    run_cmd(3'd3, AW'(20'h02000), '0, 16'sd0, 1'b1, "R10");
    // R5: settle variants
    m0 = 8'h01; d0 = 8'hB5;
    run_cmd(3'd1, '0, '0, 16'sd25, 1'b0, "R5");
    run_cmd(3'd1, '0, AW'(20'h80000), 16'sd0, 1'b0, "R5");
    run_cmd(3'd2, '0, '0, -16'sd1, 1'b0, "R5");
    run_cmd(3'd2, '0, '0, 16'sd0, 1'b0, "R5");
    m0 = 8'hC2; d0 = 8'h13;
    run_cmd(3'd1, '0, '0, -16'sd1, 1'b0, "R5");
    // R8 / R9: continuation placements and parity
    m0 = 8'h7F; d0 = 8'h7F; m1 = 8'h1C; d1 = 8'h8A;
    run_cmd(3'd1, '0, '0, 16'sd3, 1'b0, "R8");
    m0 = 8'h7F; d0 = 8'h40; m1 = 8'h00;
    run_cmd(3'd1, '0, '0, 16'sd3, 1'b0, "R9");
    m0 = 8'h03; d0 = 8'h7F; d1 = 8'h21;
    run_cmd(3'd1, '0, '0, 16'sd0, 1'b0, "R9");
    // R6 / R7: refused commands
    run_cmd(3'd1, '0, '0, -16'sd2, 1'b0, "R6");
    run_cmd(3'd2, '0, '0, -16'sd300, 1'b0, "R6");
    run_cmd(3'd0, '0, '0, -16'sd9, 1'b0, "R6");
    run_cmd(3'd6, '0, '0, 16'sd0, 1'b0, "R7");
    run_cmd(3'd7, '0, '0, 16'sd4, 1'b0, "R7");

    // random mix
    for (int k = 0; k < 16; k++) begin
      ro = 3'($urandom % 8);
      case ($urandom % 4)
        0: rs = 16'sd0;
        1: rs = 16'(1 + $urandom % 30);
        2: rs = -16'sd2 - 16'($urandom % 5);
        default: rs = (ro == 3'd2) ? -16'sd1 : 16'sd5;
      endcase
      m0 = ($urandom % 3 == 0) ? 8'h7F : 8'($urandom);
      d0 = ($urandom % 3 == 0) ? 8'h7F : 8'($urandom);
      m1 = 8'($urandom); d1 = 8'($urandom);
      run_cmd(ro, AW'($urandom), AW'($urandom), rs, 1'b0, req_of(ro));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule